// File: doc/BRIEF.md
# Scanline IRQ Counter

This block counts picture lines and interrupts the processor once a programmed number of them has gone by. The clock for the count comes from the video-memory address line A12. That line rises about once per rendered line when pattern fetches move from one table half to the other. The line is synchronised into the system clock domain. A rising edge is only accepted after the line has been low for a minimum number of system clocks, which screens out the short toggles that occur during sprite fetches.

Software loads a reload value, arms the counter by clearing it, and enables the interrupt. On each accepted line event the counter either reloads, when it holds zero, or steps down by one. When the count reaches zero after an event and the interrupt is enabled, a pending flag is set and the active-low IRQ output is asserted. A disable write acknowledges the flag. Accepted events are ignored while rendering is turned off.

Top module: `scanline_irq_counter`

## Requirements
- R1: A register write is decoded from address bits 15, 14, 13 and 0 only (address AND 0xE001). The codes are 0xC000 for the reload value, 0xC001 for counter clear, 0xE000 for disable/acknowledge and 0xE001 for enable. Any other decoded code has no effect.
- R2: A write to the reload-value register stores the data byte and leaves the current count unchanged.
- R3: A write to the counter-clear register sets the count to zero, so the next accepted event loads the reload value.
- R4: On an accepted event, a count of zero is loaded from the reload value; any other count is decremented by one.
- R5: If the count is zero after an accepted event and the interrupt is enabled, the pending flag is set. This holds even when the reload value is zero, which sets it on every event.
- R6: A write to the disable register clears the pending flag and disables the interrupt.
- R7: A write to the enable register enables the interrupt and does not clear a pending flag.
- R8: Events that arrive while render_en is low do not change the count.
- R9: A rising edge of a12_in is accepted only if the synchronised line was low for at least LOW_MIN (default 3) consecutive clocks before it. Accepted events are never on consecutive clocks.
- R10: irq_n is low exactly while the flag is pending. Reset clears the count, the reload value, the enable and the flag, so irq_n is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_en | input | 1 | Register write strobe, one clock per write |
| cpu_addr | input | 16 | Write address; only bits 15, 14, 13 and 0 are decoded |
| cpu_data | input | 8 | Write data |
| render_en | input | 1 | High while rendering is enabled; gates counting |
| a12_in | input | 1 | Asynchronous video-memory address bit 12 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Directed line sequences check reload-from-zero against plain decrement. They cover a reload value of zero, which raises the interrupt on every line, and a reload value changed mid-count, which shows that a stored value does not disturb the running count. Low periods of two and three clocks before an A12 rise separate filtered toggles from real line events. Lines with rendering off show that gating works. Writes at mirrored addresses and at non-counter codes show that decoding uses only the four address bits. Random mixes of writes and lines, with random low lengths and render states, are checked against a reference model. These mixes reach orderings such as enabling while a flag is pending, and clearing while the count is in flight.

// File: rtl/sirq_pkg.sv
// Package: shared types and register codes for the scanline IRQ counter.
// Assumes a 16-bit processor address bus where only bits 15,14,13,0 decode.
package sirq_pkg;

    localparam logic [15:0] ADDR_MASK   = 16'hE001;
    localparam logic [15:0] CODE_RELOAD = 16'hC000;
    localparam logic [15:0] CODE_CLEAR  = 16'hC001;
    localparam logic [15:0] CODE_OFF    = 16'hE000;
    localparam logic [15:0] CODE_ON     = 16'hE001;

    // One strobe per counter register; at most one is high in a cycle.
    typedef struct packed {
        logic reload_wr;
        logic clear_wr;
        logic off_wr;
        logic on_wr;
    } sirq_strobe_t;

endpackage

// File: rtl/sirq_a12_filter.sv
// Module: sirq_a12_filter
// Synchronises the asynchronous A12 line and emits a one-clock event pulse
// for a rising edge that follows at least LOW_MIN consecutive low samples.
// Assumes SYNC_STAGES >= 2 and LOW_MIN >= 1.
module sirq_a12_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_MIN     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a12_i,
    output logic event_o
);
    localparam int RUN_W = $clog2(LOW_MIN + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(LOW_MIN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [RUN_W-1:0]       run_q;
    logic                   a12_s;
    logic                   event_q;

    assign a12_s = sync_q[SYNC_STAGES-1];

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], a12_i};
    end

    // Count consecutive low samples, saturating at LOW_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= '0;
        else if (a12_s)       run_q <= '0;
        else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
    end

    // Register the qualified rising edge as a single-cycle event.
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= 1'b0;
        else        event_q <= a12_s && (run_q == RUN_SAT);
    end

    assign event_o = event_q;
endmodule

// File: rtl/sirq_reg_decode.sv
// Module: sirq_reg_decode
// Turns a processor write into per-register strobes using only address
// bits 15,14,13,0. Writes to any other decoded code produce no strobe.
module sirq_reg_decode
    import sirq_pkg::*;
(
    input  logic         wr_en_i,
    input  logic [15:0]  addr_i,
    output sirq_strobe_t strobe_o
);
    logic [15:0] code;
    logic        unused_addr_bits;

    assign code             = addr_i & ADDR_MASK;
    assign unused_addr_bits = ^addr_i[12:1];

    // Compare the masked address against each register code.
    always_comb begin
        strobe_o.reload_wr = wr_en_i && (code == CODE_RELOAD);
        strobe_o.clear_wr  = wr_en_i && (code == CODE_CLEAR);
        strobe_o.off_wr    = wr_en_i && (code == CODE_OFF);
        strobe_o.on_wr     = wr_en_i && (code == CODE_ON);
    end
endmodule

// File: rtl/sirq_count_core.sv
// Module: sirq_count_core
// Holds the reload value, the down-counter, the enable and the pending
// flag. A clear write has priority over a simultaneous line event.
// Assumes at most one register strobe per cycle.
module sirq_count_core
    import sirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sirq_strobe_t     strobe_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             event_i,
    input  logic             render_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             enable_o,
    output logic             pending_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] step_val;
    logic             enable_q;
    logic             pending_q;
    logic             fire;

    // Work out the value a line event would leave in the counter.
    always_comb begin
        fire     = event_i && render_en_i;
        step_val = (count_q == '0) ? reload_q : count_q - 1'b1;
    end

    // Store the reload value on its register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  reload_q <= '0;
        else if (strobe_i.reload_wr) reload_q <= data_i;
    end

    // Advance or clear the down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count_q <= '0;
        else if (strobe_i.clear_wr) count_q <= '0;
        else if (fire)              count_q <= step_val;
    end

    // Track the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)               enable_q <= 1'b0;
        else if (strobe_i.off_wr) enable_q <= 1'b0;
        else if (strobe_i.on_wr)  enable_q <= 1'b1;
    end

    // Set the pending flag at zero after an event; clear it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (strobe_i.off_wr)
            pending_q <= 1'b0;
        else if (fire && !strobe_i.clear_wr && enable_q && step_val == '0)
            pending_q <= 1'b1;
    end

    assign count_o   = count_q;
    assign enable_o  = enable_q;
    assign pending_o = pending_q;
endmodule

// File: rtl/scanline_irq_counter.sv
// Module: scanline_irq_counter
// Top level: filters A12 into line events, decodes processor writes and
// drives an active-low interrupt from the pending flag.
// Assumes cpu_wr_en is a single-clock strobe synchronous to clk.
module scanline_irq_counter
    import sirq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_MIN     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_en,
    input  logic [15:0]      cpu_addr,
    input  logic [CNT_W-1:0] cpu_data,
    input  logic             render_en,
    input  logic             a12_in,
    output logic             irq_n
);
    sirq_strobe_t     strobe_w;
    logic             event_w;
    logic [CNT_W-1:0] count_w;
    logic             enable_w;
    logic             pending_w;

    sirq_a12_filter #(.SYNC_STAGES(SYNC_STAGES), .LOW_MIN(LOW_MIN)) filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a12_i   (a12_in),
        .event_o (event_w)
    );

    sirq_reg_decode dec_i (
        .wr_en_i  (cpu_wr_en),
        .addr_i   (cpu_addr),
        .strobe_o (strobe_w)
    );

    sirq_count_core #(.CNT_W(CNT_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe_w),
        .data_i      (cpu_data),
        .event_i     (event_w),
        .render_en_i (render_en),
        .count_o     (count_w),
        .enable_o    (enable_w),
        .pending_o   (pending_w)
    );

    assign irq_n = ~pending_w;
endmodule

// File: rtl/sirq_checker.sv
// Module: sirq_checker
// Temporal checks on the scanline IRQ counter, bound into the top level.
module sirq_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      addr,
    input logic             render_en,
    input logic             ev,
    input logic [CNT_W-1:0] count,
    input logic             enable,
    input logic             irq_n
);
    logic [15:0] code;
    assign code = addr & 16'hE001;

    assert_reload_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && code == 16'hC000 && !(ev && render_en) |=> $stable(count));

    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && code == 16'hC001 |=> count == '0);

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev && render_en && count != '0 && !wr_en |=> count == $past(count) - 1'b1);

    assert_flag_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev && render_en && count == 1 && enable && !wr_en |=> !irq_n);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && code == 16'hE000 |=> irq_n && !enable);

    assert_enable_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && code == 16'hE001 && !irq_n |=> !irq_n && enable);

    assert_gated_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !render_en && !wr_en |=> $stable(count));

    assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ev);
endmodule

bind scanline_irq_counter sirq_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cpu_wr_en),
    .addr      (cpu_addr),
    .render_en (render_en),
    .ev        (event_w),
    .count     (count_w),
    .enable    (enable_w),
    .irq_n     (irq_n)
);

// File: tb/scanline_irq_counter_tb_top.sv
module scanline_irq_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        render_en = 1'b1;
    logic        a12_in = 1'b1;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_cnt = '0;
    logic [7:0] m_rel = '0;
    bit         m_en = 0;
    bit         m_flag = 0;

    always #2.5 clk = ~clk;

    scanline_irq_counter dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .render_en(render_en), .a12_in(a12_in), .irq_n(irq_n)
    );

    function automatic void model_write(logic [15:0] a, logic [7:0] d);
        case (a & 16'hE001)
            16'hC000: m_rel = d;
            16'hC001: m_cnt = '0;
            16'hE000: begin m_flag = 0; m_en = 0; end
            16'hE001: m_en = 1;
            default: ;
        endcase
    endfunction

    function automatic void model_event();
        if (m_cnt == 0) m_cnt = m_rel;
        else            m_cnt = m_cnt - 8'd1;
        if (m_cnt == 0 && m_en) m_flag = 1;
    endfunction

    task automatic check_irq(string req);
        checks++;
        if (irq_n !== !m_flag) begin
            errors++;
            $display("FAIL %s irq_n actual %b expected %b", req, irq_n, !m_flag);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        model_write(a, d);
    endtask

    // Drive A12 low for low_len clocks, then high; model the event.
    task automatic line(int low_len, bit ren);
        @(negedge clk);
        render_en = ren;
        a12_in = 1'b0;
        repeat (low_len) @(negedge clk);
        a12_in = 1'b1;
        repeat (6) @(negedge clk);
        if (low_len >= 3 && ren) model_event();
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_irq("R10 reset");

        // R3/R4/R5: reload 2 then count down to zero
        wr(16'hE001, 8'h00);
        wr(16'hC000, 8'd2);
        wr(16'hC001, 8'h00);
        check_irq("R3 clear");
        line(4, 1); check_irq("R4 reload from zero");
        line(4, 1); check_irq("R4 decrement");
        line(4, 1); check_irq("R5 zero sets flag");
        wr(16'hE001, 8'h00); check_irq("R7 enable keeps flag");
        wr(16'hE000, 8'h00); check_irq("R6 acknowledge");
        line(4, 1); check_irq("R6 disabled no flag");

        // R1: mirrored addresses and non-counter codes
        wr(16'hDFFE, 8'd1);
        wr(16'hFFFF, 8'h00);
        wr(16'hDDDD, 8'h00);
        wr(16'h8001, 8'h00);
        wr(16'hA000, 8'hFF);
        wr(16'hBFFF, 8'h00);
        line(4, 1); check_irq("R1 mirror reload");
        line(4, 1); check_irq("R1 mirror flag");
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);

        // R8: render off
        wr(16'hC000, 8'd1);
        wr(16'hC001, 8'h00);
        line(4, 1);
        line(4, 0); check_irq("R8 gated line");
        line(4, 1); check_irq("R8 resumed line");
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);

        // R9: low-time filter
        wr(16'hC000, 8'd1);
        wr(16'hC001, 8'h00);
        line(4, 1);
        line(2, 1); check_irq("R9 short low ignored");
        line(3, 1); check_irq("R9 minimum low accepted");
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);

        // R5: reload value zero fires every line
        wr(16'hC000, 8'd0);
        wr(16'hC001, 8'h00);
        line(4, 1); check_irq("R5 zero reload");
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        line(4, 1); check_irq("R5 zero reload again");
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);

        // R2: reload value change mid-count
        wr(16'hC000, 8'd5);
        wr(16'hC001, 8'h00);
        line(4, 1);
        wr(16'hC000, 8'd2);
        for (int i = 0; i < 5; i++) begin
            line(4, 1); check_irq("R2 count kept");
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom % 10);
            if (op < 5) begin
                logic [15:0] a;
                logic [15:0] base;
                base = 16'($urandom) & 16'h1FFE;
                case ($urandom % 7)
                    0: a = base | 16'hC000;
                    1: a = base | 16'hC001;
                    2: a = base | 16'hE000;
                    3: a = base | 16'hE001;
                    4: a = base | 16'h8000;
                    5: a = base | 16'hA001;
                    default: a = base | 16'hE001;
                endcase
                wr(a, 8'($urandom % 6));
                check_irq("R1 random write");
            end else begin
                line(int'($urandom % 5) + 1, ($urandom % 6) != 0);
                check_irq("R4 random line");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule